// File: doc/BRIEF.md
# Receive Test-Pattern Checker

This block sits behind a receive channel's character decoder during built-in self-test. It compares each received 8-bit character against a pseudo-random sequence that it generates itself. Every character clock it reports a 3-bit status code, carried on one status line and two data lines. The code tells whether the checker is starting, waiting for the start-of-sequence marker, matching, seeing a bit error, or closing a sequence with a good or bad final character.

The upstream logic supplies a self-test enable, a lock flag from the clock-recovery loop, the decoded character, and a flag that marks the start-of-sequence character. After the marker is seen, the internal LFSR is loaded with a fixed seed. From then on every character is compared with the LFSR output. Sequences run back to back with no need for a new marker, until lock is lost or self-test is disabled.

Top module: `rx_bist_checker`

## Requirements
- R1: The status code is {st_bit, dl0, dl1}. While bist_en is low, the code is 000 after the next clock edge, whatever the other inputs are. After reset the code is 000.
- R2: When bist_en rises with pll_locked high, the next edge reports 101 (start), and the edge after that reports 111 (wait).
- R3: Code 011 is never produced.
- R4: In the wait state the code stays 111 until a character arrives with rx_sof high. That marker character is itself reported as 111 and is not compared. Comparison begins with the character that follows it.
- R5: The expected value of the first compared character is the seed 0x01. Each following expected value is the previous one shifted left by one bit, with bit 7 ^ bit 5 ^ bit 4 ^ bit 3 of the previous value entering at bit 0 (polynomial x^8+x^6+x^5+x^4+1).
- R6: A compared character that is not the last of its sequence reports 000 when it equals the expected value and 110 when any bit differs. An error is not sticky: the next matching character reports 000. The expected sequence advances whether or not the character matched.
- R7: The 511th compared character of a sequence reports 010 if it matches and 100 if it does not.
- R8: After the 511th character the checker reloads the seed and compares the next character against 0x01, without returning to the wait state.
- R9: While bist_en is high and pll_locked is low, the code after each edge is 101. When lock returns, the next edge reports 111, and a new rx_sof marker is needed before comparison resumes.
- R10: Each status code appears one clock edge after the character it describes is sampled.
- R11: After bist_en is dropped and raised again, the checker passes through 101 and 111 and needs a new marker; it keeps no earlier synchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_en | input | 1 | Receive self-test enable |
| pll_locked | input | 1 | Clock-recovery lock indication |
| rx_char | input | 8 | Received decoded character |
| rx_sof | input | 1 | Current character is the start-of-sequence marker |
| st_bit | output | 1 | Status code bit 2 |
| dl0 | output | 1 | Status code bit 1 (data lane 0) |
| dl1 | output | 1 | Status code bit 0 (data lane 1) |

## Verification
The embedded assertions check four things every cycle: the reserved code never appears, disable and unlock force their codes on the following edge, the wait code persists while no marker arrives, and the sequence position closes with a last-good or last-bad code. Only the directed scenarios can show that the expected values follow the stated polynomial and seed, and that single-bit errors do not stick. They also cover reseeding across a sequence boundary and the need for a fresh marker after a lock loss or re-enable. For these, the bench feeds a stream generated from the requirement's own recurrence and compares every code cycle by cycle.

// File: rtl/rx_bist_checker.sv
module rx_bist_checker #(
  parameter int unsigned      W       = 8,
  parameter int unsigned      SEQ_LEN = 511,
  parameter logic [W-1:0]     SEED    = 8'h01,
  parameter logic [W-1:0]     TAPS    = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bist_en,
  input  logic         pll_locked,
  input  logic [W-1:0] rx_char,
  input  logic         rx_sof,
  output logic         st_bit,
  output logic         dl0,
  output logic         dl1
);

  localparam int unsigned CW = $clog2(SEQ_LEN);
  localparam logic [CW-1:0] LAST_IDX = CW'(SEQ_LEN - 1);

  localparam logic [2:0] C_MATCH = 3'b000;
  localparam logic [2:0] C_LGOOD = 3'b010;
  localparam logic [2:0] C_LBAD  = 3'b100;
  localparam logic [2:0] C_START = 3'b101;
  localparam logic [2:0] C_ERR   = 3'b110;
  localparam logic [2:0] C_WAIT  = 3'b111;

  typedef enum logic [1:0] {S_IDLE, S_START, S_WAIT, S_RUN} st_t;

  st_t           state;
  logic [W-1:0]  lfsr;
  logic [CW-1:0] idx;
  logic [2:0]    code;

  wire           fb      = ^(lfsr & TAPS);
  wire [W-1:0]   lfsr_nx = {lfsr[W-2:0], fb};
  wire           hit     = (rx_char == lfsr);
  wire           at_last = (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      lfsr  <= '0;
      idx   <= '0;
      code  <= C_MATCH;
    end else if (!bist_en) begin
      state <= S_IDLE;
      lfsr  <= '0;
      idx   <= '0;
      code  <= C_MATCH;
    end else if (!pll_locked) begin
      state <= S_START;
      code  <= C_START;
    end else begin
      case (state)
        S_IDLE: begin
          state <= S_START;
          code  <= C_START;
        end
        S_START: begin
          state <= S_WAIT;
          code  <= C_WAIT;
        end
        S_WAIT: begin
          code <= C_WAIT;
          if (rx_sof) begin
            state <= S_RUN;
            lfsr  <= SEED;
            idx   <= '0;
          end
        end
        default: begin
          if (at_last) begin
            code <= hit ? C_LGOOD : C_LBAD;
            lfsr <= SEED;
            idx  <= '0;
          end else begin
            code <= hit ? C_MATCH : C_ERR;
            lfsr <= lfsr_nx;
            idx  <= idx + CW'(1);
          end
        end
      endcase
    end
  end

  assign st_bit = code[2];
  assign dl0    = code[1];
  assign dl1    = code[0];

  a_r3_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    {st_bit, dl0, dl1} != 3'b011);

  a_r1_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bist_en |=> {st_bit, dl0, dl1} == 3'b000);

  a_r9_unlock_start: assert property (@(posedge clk) disable iff (!rst_n)
    bist_en && !pll_locked |=> {st_bit, dl0, dl1} == 3'b101);

  a_r4_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WAIT && bist_en && pll_locked && !rx_sof
      |=> state == S_WAIT && {st_bit, dl0, dl1} == 3'b111);

  a_r7_last_report: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_RUN && at_last && bist_en && pll_locked
      |=> ({st_bit, dl0, dl1} == 3'b010 || {st_bit, dl0, dl1} == 3'b100));

  a_r8_reseed: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_RUN && at_last && bist_en && pll_locked
      |=> state == S_RUN && lfsr == SEED && idx == '0);

endmodule

// File: tb/tb_rx_bist_checker.sv
`timescale 1ns/1ps
module tb_rx_bist_checker;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bist_en = 0;
  logic       pll_locked = 0;
  logic [7:0] rx_char = '0;
  logic       rx_sof = 0;
  logic       st_bit, dl0, dl1;

  int checks = 0;
  int errors = 0;
  bit saw_reserved = 0;
  logic [7:0] exp_val;
  int         pos;

  rx_bist_checker dut (.*);

  always #4 clk = ~clk;

  always @(negedge clk)
    if (rst_n && {st_bit, dl0, dl1} === 3'b011) saw_reserved = 1;

  function automatic logic [7:0] nxt(input logic [7:0] v);
    return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
  endfunction

  task automatic check(input logic [2:0] got, input logic [2:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // drive one character, return the code reported after the next edge
  task automatic step(input logic [7:0] c, input logic sof, output logic [2:0] code);
    rx_char = c;
    rx_sof  = sof;
    @(posedge clk);
    #1;
    code = {st_bit, dl0, dl1};
  endtask

  task automatic feed(input bit corrupt, input int bitpos, input string req);
    logic [2:0] c;
    logic [2:0] e;
    logic [7:0] d;
    d = corrupt ? (exp_val ^ (8'h01 << bitpos)) : exp_val;
    step(d, 0, c);
    if (pos == 510) e = corrupt ? 3'b100 : 3'b010;
    else            e = corrupt ? 3'b110 : 3'b000;
    check(c, e, req);
    if (pos == 510) begin exp_val = 8'h01; pos = 0; end
    else begin exp_val = nxt(exp_val); pos++; end
  endtask

  task automatic t_reset;
    check({st_bit, dl0, dl1}, 3'b000, "R1 reset");
  endtask

  task automatic t_enable;
    logic [2:0] c;
    pll_locked = 1; bist_en = 1;
    step(8'h00, 0, c); check(c, 3'b101, "R2 start");
    step(8'h01, 0, c); check(c, 3'b111, "R2 wait");
    for (int i = 0; i < 3; i++) begin
      step(8'h01, 0, c); check(c, 3'b111, "R4 wait holds");
    end
  endtask

  task automatic t_sync;
    logic [2:0] c;
    step(8'hBC, 1, c); check(c, 3'b111, "R4 marker not compared");
    exp_val = 8'h01; pos = 0;
    for (int i = 0; i < 20; i++) feed(0, 0, "R5 R10 match");
  endtask

  task automatic t_errors;
    feed(1, 0, "R6 error bit0");
    feed(0, 0, "R6 not sticky");
    feed(1, 7, "R6 error bit7");
    feed(1, 3, "R6 error bit3");
    feed(0, 0, "R6 recover");
  endtask

  task automatic t_last;
    while (pos != 510) feed(0, 0, "R5 sweep");
    feed(0, 0, "R7 last good");
    feed(0, 0, "R8 reseed");
    feed(0, 0, "R8 continue");
    while (pos != 510) feed(0, 0, "R5 sweep2");
    feed(1, 4, "R7 last bad");
    feed(0, 0, "R8 reseed after bad");
  endtask

  task automatic t_unlock;
    logic [2:0] c;
    for (int i = 0; i < 7; i++) feed(0, 0, "R6 pre-unlock");
    pll_locked = 0;
    step(exp_val, 0, c); check(c, 3'b101, "R9 unlock start");
    step(exp_val, 0, c); check(c, 3'b101, "R9 unlock holds");
    pll_locked = 1;
    step(8'h01, 0, c); check(c, 3'b111, "R9 relock wait");
    step(8'h01, 0, c); check(c, 3'b111, "R9 needs marker");
    step(8'hBC, 1, c); check(c, 3'b111, "R9 marker");
    exp_val = 8'h01; pos = 0;
    for (int i = 0; i < 4; i++) feed(0, 0, "R9 resumed");
  endtask

  task automatic t_disable;
    logic [2:0] c;
    bist_en = 0;
    step(8'h55, 1, c); check(c, 3'b000, "R1 disabled");
    pll_locked = 0;
    step(8'hAA, 0, c); check(c, 3'b000, "R1 disabled unlocked");
    pll_locked = 1;
    step(8'h01, 1, c); check(c, 3'b000, "R1 disabled marker");
    bist_en = 1;
    step(8'h01, 0, c); check(c, 3'b101, "R11 reenable start");
    step(8'h01, 0, c); check(c, 3'b111, "R11 reenable wait");
    step(8'h01, 0, c); check(c, 3'b111, "R11 no old sync");
    step(8'hBC, 1, c); check(c, 3'b111, "R11 marker");
    exp_val = 8'h01; pos = 0;
    feed(0, 0, "R11 resumed");
    feed(1, 1, "R11 error after resume");
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    rst_n = 1;
    @(posedge clk); #1;
    t_enable;
    t_sync;
    t_errors;
    t_last;
    t_unlock;
    t_disable;
    checks++;
    if (saw_reserved) begin
      errors++;
      $display("FAIL R3: got 011 expected never");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule